// File: doc/BRIEF.md
# CAN Bus Self Wake-Up Detector

This block watches the received CAN line while the controller sleeps. It reports a wake-up when the line falls from recessive (logic 1) to dominant (logic 0). The raw receive input first passes through a two-stage synchronizer. A falling edge at the synchronizer output counts as an event only under two conditions: the self-wake enable is set, and the controller is in one of the two watched low-power modes, doze or stop. In the off (disabled) mode and in normal running the detector stays quiet.

The response depends on the mode. In doze, an event asks for the clocks back at once. In stop, the interrupt comes first, so the system can leave stop, and the clock request is raised one cycle later. The wake interrupt is raised only when its enable is set. It stays high until software writes a one to the clear strobe. The self-wake enable is held in the block and can be written only while running or off. Writes made while a watched mode is active are dropped.

Top module: `can_wake_detect`

## Requirements
- R1: After a synchronous reset, `clk_req`, `wake_irq` and `wake_en` are all 0.
- R2: An event is a 1-to-0 change at the synchronizer output. A 0-to-1 change or a steady level causes nothing. If `rx_async` falls before clock edge e0, the outputs respond after edge e0+2.
- R3: In doze mode (`mode_i` = 2'b01), an event sets `clk_req` at the same edge that the interrupt would be set.
- R4: In stop mode (`mode_i` = 2'b10), an event sets `wake_irq` after edge e0+2 and sets `clk_req` one edge later.
- R5: In running mode (`mode_i` = 2'b00) and off mode (2'b11), nothing is detected, and `clk_req` is 0 one cycle after such a mode is seen.
- R6: While `wake_en` is 0, bus edges have no effect on either output.
- R7: A write through `en_wr`/`en_wdata` updates `wake_en` one cycle later, but only in running or off mode. In doze or stop the write is ignored.
- R8: With `irq_en` low, an event raises no interrupt, but the clock request still follows R3/R4.
- R9: `wake_irq` stays high until `irq_clr` is seen high. If an event and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_async | input | 1 | Raw CAN receive line, 1 = recessive |
| mode_i | input | 2 | 00 run, 01 doze, 10 stop, 11 off |
| en_wr | input | 1 | Write strobe for the self-wake enable |
| en_wdata | input | 1 | Value written to the self-wake enable |
| irq_en | input | 1 | Wake interrupt enable |
| irq_clr | input | 1 | Write-1-to-clear for the wake interrupt |
| clk_req | output | 1 | Request to resume clocks |
| wake_irq | output | 1 | Sticky wake-up interrupt flag |
| wake_en | output | 1 | Current self-wake enable state |

## Verification
A wrong synchronizer or edge register shows up as a wake-up that comes a cycle early or late, or as one raised on a rising edge. The per-cycle comparison catches it at edge e0+2. A stop-mode event that skips its pending stage drives `clk_req` one cycle early, and that shows on the first event in stop. A broken write lock shows on `wake_en` in the cycle after a write made in doze or stop. A lost sticky hold shows as `wake_irq` dropping with no clear applied.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_DOZE = 2'b01,
    MODE_STOP = 2'b10,
    MODE_OFF  = 2'b11
  } pwr_mode_e;

  function automatic logic is_watched(input pwr_mode_e m);
    return (m == MODE_DOZE) || (m == MODE_STOP);
  endfunction
endpackage

// File: rtl/can_wake_sync.sv
module can_wake_sync #(
  parameter int   STAGES    = 2,
  parameter logic IDLE_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE_LVL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_LVL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/can_wake_edge.sv
module can_wake_edge #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic arm,
  output logic fall
);
  logic last_lvl;

  always_ff @(posedge clk) begin
    if (rst) last_lvl <= IDLE_LVL;
    else     last_lvl <= level;
  end

  // recessive-to-dominant change, counted only while armed
  assign fall = arm && (last_lvl == IDLE_LVL) && (level != IDLE_LVL);
endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl
  import can_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pwr_mode_e mode,
  input  logic      fall,
  input  logic      irq_en,
  input  logic      irq_clr,
  input  logic      en_wr,
  input  logic      en_wdata,
  output logic      wake_en,
  output logic      clk_req,
  output logic      wake_irq,
  output logic      stop_pend
);
  logic watched;
  assign watched = is_watched(mode);

  // enable bit: locked while a watched mode is active
  always_ff @(posedge clk) begin
    if (rst)                   wake_en <= 1'b0;
    else if (en_wr && !watched) wake_en <= en_wdata;
  end

  // sticky interrupt, set wins over clear
  always_ff @(posedge clk) begin
    if (rst)                  wake_irq <= 1'b0;
    else if (fall && irq_en)  wake_irq <= 1'b1;
    else if (irq_clr)         wake_irq <= 1'b0;
  end

  // stop-mode event defers the clock request by one stage
  always_ff @(posedge clk) begin
    if (rst) stop_pend <= 1'b0;
    else     stop_pend <= fall && (mode == MODE_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst)                              clk_req <= 1'b0;
    else if (!watched)                    clk_req <= 1'b0;
    else if (stop_pend)                   clk_req <= 1'b1;
    else if (fall && (mode == MODE_DOZE)) clk_req <= 1'b1;
  end
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
  import can_wake_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RECESSIVE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_async,
  input  logic [1:0] mode_i,
  input  logic       en_wr,
  input  logic       en_wdata,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       clk_req,
  output logic       wake_irq,
  output logic       wake_en
);
  pwr_mode_e mode_w;
  logic      rx_sync_w;
  logic      arm_w;
  logic      fall_w;
  logic      pend_w;

  assign mode_w = pwr_mode_e'(mode_i);
  assign arm_w  = wake_en && is_watched(mode_w);

  can_wake_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(RECESSIVE)) sync_i (
    .clk(clk), .rst(rst), .d(rx_async), .q(rx_sync_w)
  );

  can_wake_edge #(.IDLE_LVL(RECESSIVE)) edge_i (
    .clk(clk), .rst(rst), .level(rx_sync_w), .arm(arm_w), .fall(fall_w)
  );

  can_wake_ctrl ctrl_i (
    .clk(clk), .rst(rst), .mode(mode_w), .fall(fall_w),
    .irq_en(irq_en), .irq_clr(irq_clr), .en_wr(en_wr), .en_wdata(en_wdata),
    .wake_en(wake_en), .clk_req(clk_req), .wake_irq(wake_irq),
    .stop_pend(pend_w)
  );
endmodule

// File: rtl/can_wake_chk.sv
module can_wake_chk
  import can_wake_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       fall,
  input logic       stop_pend,
  input logic       irq_en,
  input logic       irq_clr,
  input logic       clk_req,
  input logic       wake_irq,
  input logic       wake_en
);
  logic watched;
  assign watched = (mode == MODE_DOZE) || (mode == MODE_STOP);

  a_r3_doze_req: assert property (@(posedge clk) disable iff (rst)
    (fall && mode == MODE_DOZE) |=> clk_req);

  a_r4_stop_late: assert property (@(posedge clk) disable iff (rst)
    (fall && mode == MODE_STOP && !clk_req && !stop_pend) |=> !clk_req);

  a_r4_stop_follow: assert property (@(posedge clk) disable iff (rst)
    (stop_pend && watched) |=> clk_req);

  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !watched |=> !clk_req);

  a_r7_lock: assert property (@(posedge clk) disable iff (rst)
    watched |=> $stable(wake_en));

  a_r8_no_irq: assert property (@(posedge clk) disable iff (rst)
    (fall && !irq_en && !wake_irq) |=> !wake_irq);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && !irq_clr) |=> wake_irq);
endmodule

bind can_wake_detect can_wake_chk chk_i (
  .clk(clk), .rst(rst), .mode(mode_i), .fall(fall_w), .stop_pend(pend_w),
  .irq_en(irq_en), .irq_clr(irq_clr), .clk_req(clk_req),
  .wake_irq(wake_irq), .wake_en(wake_en)
);

// File: tb/can_wake_detect_tb_top.sv
`timescale 1ns/1ps
module can_wake_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_async = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       en_wr = 1'b0, en_wdata = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic       clk_req, wake_irq, wake_en;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  can_wake_detect dut_i (
    .clk(clk), .rst(rst), .rx_async(rx_async), .mode_i(mode_i),
    .en_wr(en_wr), .en_wdata(en_wdata), .irq_en(irq_en), .irq_clr(irq_clr),
    .clk_req(clk_req), .wake_irq(wake_irq), .wake_en(wake_en)
  );

  // behavioural reference model
  bit rxq[$] = '{1'b1, 1'b1, 1'b1};  // [0] newest sample .. [2] previous synced
  bit m_en = 0, m_irq = 0, m_req = 0, m_pend = 0;

  always @(posedge clk) begin
    bit ev, watch, n_pend, n_req;
    if (rst) begin
      rxq = '{1'b1, 1'b1, 1'b1};
      m_en = 0; m_irq = 0; m_req = 0; m_pend = 0;
    end else begin
      watch  = (mode_i == 2'b01) || (mode_i == 2'b10);
      ev     = m_en && watch && rxq[2] && !rxq[1];
      n_pend = ev && (mode_i == 2'b10);
      n_req  = m_req;
      if (!watch)                     n_req = 0;
      else if (m_pend)                n_req = 1;
      else if (ev && mode_i == 2'b01) n_req = 1;
      if (ev && irq_en) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (en_wr && !watch) m_en = en_wdata;
      m_pend = n_pend;
      m_req  = n_req;
      rxq.push_front(rx_async);
      void'(rxq.pop_back());
    end
  end

  task automatic check(string name, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("clk_req", clk_req, m_req);
      check("wake_irq", wake_irq, m_irq);
      check("wake_en", wake_en, m_en);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_low(int len);
    rx_async = 0; cyc(len); rx_async = 1; cyc(4);
  endtask

  task automatic write_en(bit v);
    en_wr = 1; en_wdata = v; cyc(1); en_wr = 0; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst = 0;
    cur_req = "R1"; cyc(1);
    check("reset clk_req", clk_req, 0);
    check("reset wake_irq", wake_irq, 0);
    check("reset wake_en", wake_en, 0);

    cur_req = "R7";
    write_en(1); check("en write in run", wake_en, 1);
    mode_i = 2'b01; cyc(1); write_en(0); check("en write in doze ignored", wake_en, 1);
    mode_i = 2'b10; cyc(1); write_en(0); check("en write in stop ignored", wake_en, 1);
    mode_i = 2'b11; cyc(1); write_en(0); check("en write in off", wake_en, 0);
    write_en(1);

    cur_req = "R3"; irq_en = 1; mode_i = 2'b01; cyc(2);
    rx_async = 0; cyc(2);
    check("doze req not yet", clk_req, 0);
    cyc(1); check("doze req at e0+2", clk_req, 1);
    check("doze irq at e0+2", wake_irq, 1);
    rx_async = 1; cyc(4);

    cur_req = "R9"; cyc(3); check("irq sticky", wake_irq, 1);
    irq_clr = 1; cyc(1); irq_clr = 0; check("irq cleared", wake_irq, 0);

    cur_req = "R5"; mode_i = 2'b00; cyc(1); check("req drops in run", clk_req, 0);
    pulse_low(3); pulse_low(1);

    cur_req = "R4"; mode_i = 2'b10; cyc(2);
    rx_async = 0; cyc(3);
    check("stop irq at e0+2", wake_irq, 1);
    check("stop req late", clk_req, 0);
    cyc(1); check("stop req follows", clk_req, 1);
    rx_async = 1; cyc(4);
    irq_clr = 1; cyc(1); irq_clr = 0;
    mode_i = 2'b11; cyc(1);

    cur_req = "R5"; pulse_low(2); pulse_low(5);
    check("off no req", clk_req, 0); check("off no irq", wake_irq, 0);

    cur_req = "R8"; irq_en = 0; mode_i = 2'b01; cyc(2); pulse_low(3);
    check("doze no irq", wake_irq, 0); check("doze req w/o irq", clk_req, 1);
    mode_i = 2'b00; cyc(1); mode_i = 2'b10; cyc(2); pulse_low(2);
    check("stop req w/o irq", clk_req, 1);
    mode_i = 2'b00; cyc(2);

    cur_req = "R2"; irq_en = 1; rx_async = 0; cyc(4);
    mode_i = 2'b01; cyc(2); rx_async = 1; cyc(5);
    check("rise only no req", clk_req, 0); check("rise only no irq", wake_irq, 0);
    cyc(6); check("steady no irq", wake_irq, 0);
    pulse_low(1); check("one-cycle low detected", wake_irq, 1);

    cur_req = "R9"; irq_clr = 1; rx_async = 0; cyc(6);
    check("set wins over clear", wake_irq, 0);
    rx_async = 1; cyc(2); irq_clr = 0; cyc(1);
    rx_async = 0; cyc(1); irq_clr = 1; cyc(1); irq_clr = 1; cyc(1);
    irq_clr = 0; cyc(1);
    check("set wins at same edge", wake_irq, 1);
    rx_async = 1; irq_clr = 1; cyc(1); irq_clr = 0;
    mode_i = 2'b00; cyc(2);

    cur_req = "R6"; write_en(0);
    mode_i = 2'b01; cyc(2); pulse_low(3);
    mode_i = 2'b10; cyc(2); pulse_low(3);
    check("disabled no req", clk_req, 0); check("disabled no irq", wake_irq, 0);

    cur_req = "R1"; rst = 1; cyc(2); rst = 0; mode_i = 2'b00; cyc(2);
    check("re-reset en", wake_en, 0);
    finish_run();
  end
endmodule